// File: doc/BRIEF.md
# T1 Pulse Density Monitor and Enforcer

This block watches a serial T1 bit stream, one bit per cycle in which a valid strobe is high, and checks it against two ones-density rules. The first rule limits a run of zeros to fifteen. The second is a family of nested sliding windows: for each N from 1 to 23, any 8·(N+1) consecutive bits must hold at least N ones, so the widest window spans 192 bits. A violation pulse marks each bit at which any rule is broken.

In monitor mode the bit passes through unchanged. In enforce mode the block turns a zero into a one whenever sending the zero would break a rule. The rules are then checked on the outgoing stream, and the forced one counts as a one in all later windows. Enforcement must stay off for a stream that carries B8ZS zero substitution, because that coding already meets the density rules. A chip uses one instance on the transmit path and a second on the receive path, so each direction has its own violation pulse.

Internally the block keeps the ages of the 23 most recent ones. Rule N fails at the current bit when the N-th most recent one, counting the current bit, is at least 8·(N+1) bits old.

Top module: `pdm_density_guard`

## Requirements
- R1: While reset is asserted, and immediately after it, `out_vld`, `viol` and `bit_out` are 0. After reset the bit history is empty and the count of bits seen is zero.
- R2: The zero-run rule is checked from the first bit after reset. An outgoing zero that follows 15 or more consecutive outgoing zeros raises `viol` for that bit. A one ends the run.
- R3: For every N from 1 to 23, a bit raises `viol` when the 8·(N+1)-bit window that ends with it holds fewer than N outgoing ones. This check is made only on bits that arrive after 192 valid bits have been seen since reset.
- R4: With `enforce_en` at 0, `bit_out` equals the input bit and the rules are checked on the input stream.
- R5: With `enforce_en` at 1, an input zero becomes a one exactly when an outgoing zero would break R2 or R3. Input ones always pass as ones. The rules are checked on the outgoing bit, and `enforce_en` is sampled with each bit.
- R6: A forced one enters the history as a one and counts toward later zero runs and windows.
- R7: A bit presented with `bit_vld` high at a clock edge produces `bit_out`, `viol` and a one-cycle `out_vld` pulse on the following cycle. `viol` is never high without `out_vld`.
- R8: Cycles with `bit_vld` low leave the history, the zero run and the bits-seen count unchanged, whatever `bit_in` holds in those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Incoming stream bit |
| bit_vld | input | 1 | High when `bit_in` carries a stream bit |
| enforce_en | input | 1 | 1 = force ones where needed, 0 = monitor only |
| bit_out | output | 1 | Outgoing stream bit, registered |
| out_vld | output | 1 | One-cycle strobe marking a new `bit_out` |
| viol | output | 1 | High when the marked bit breaks a density rule |

## Verification
A long zero run right after reset shows that the zero-run rule is active while the window checks are still held off. A one-in-fifteen pattern that crosses the 192-bit mark separates bits that are suppressed from bits that are checked. All-ones, one-in-eight and one-in-nine streams separate a stream that meets every window from one that fails only the wide windows. An all-zero stream and a sparse pseudo-random stream under enforcement show where ones are forced and how those ones feed back into later windows. Idle cycles with a one on the input, enforcement toggled from bit to bit, and a reset in the middle of a run show that only valid bits count and that reset clears the history.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  // Outcome of the rule check for both possible outgoing bit values.
  typedef struct packed {
    logic if_zero;  // a zero at this position would break a rule
    logic if_one;   // a one at this position would break a rule
  } pdm_verdict_t;

  // Length in bits of the window that must hold n ones.
  function automatic int win_len(input int step, input int n);
    return step * (n + 1);
  endfunction

  // Age of a stored one after one more bit, held at the cap.
  function automatic int age_next(input int age, input int cap);
    return (age >= cap) ? cap : age + 1;
  endfunction

  // Zero-run length after one more bit, held at the limit.
  function automatic int run_next(input int run, input int lim, input logic one);
    if (one) return 0;
    return (run >= lim) ? lim : run + 1;
  endfunction

endpackage

// File: rtl/pdm_age_hist.sv
module pdm_age_hist #(
  parameter int NMAX    = 23,
  parameter int AGE_W   = 8,
  parameter int AGE_CAP = 192
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic                       one_in,
  output logic [NMAX-1:0][AGE_W-1:0] age
);

  // Slot 0 holds the age of the most recent one, measured to the next bit.
  // A slot at AGE_CAP means no one is present within the widest window.
  for (genvar k = 0; k < NMAX; k++) begin : g_slot
    logic [AGE_W-1:0] slot_q;
    logic [AGE_W-1:0] src;

    if (k == 0) begin : g_head
      assign src = '0;
    end else begin : g_tail
      assign src = age[k-1];

      // R6
      age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        age[k-1] <= age[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= AGE_W'(AGE_CAP);
      end else if (adv) begin
        if (one_in)
          slot_q <= AGE_W'(pdm_pkg::age_next(int'(src), AGE_CAP));
        else
          slot_q <= AGE_W'(pdm_pkg::age_next(int'(slot_q), AGE_CAP));
      end
    end

    assign age[k] = slot_q;
  end

  // R8
  hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(age));

  // R6
  newest_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && one_in |=> age[0] == AGE_W'(1));

endmodule

// File: rtl/pdm_run_track.sv
module pdm_run_track #(
  parameter int ZMAX = 15,
  parameter int ZW   = 4,
  parameter int WMAX = 192,
  parameter int SW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          one_in,
  output logic [ZW-1:0] zrun,
  output logic          warm
);

  logic [SW-1:0] seen_q;
  logic [ZW-1:0] zrun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun_q <= '0;
      seen_q <= '0;
    end else if (adv) begin
      zrun_q <= ZW'(pdm_pkg::run_next(int'(zrun_q), ZMAX, one_in));
      if (int'(seen_q) < WMAX) seen_q <= seen_q + 1'b1;
    end
  end

  assign zrun = zrun_q;
  assign warm = (int'(seen_q) == WMAX);

  // R2
  zrun_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(zrun) <= ZMAX);

  // R2
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && one_in |=> zrun == '0);

  // R3
  warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |=> warm);

  // R8
  run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(zrun) && $stable(warm));

endmodule

// File: rtl/pdm_rule_eval.sv
module pdm_rule_eval #(
  parameter int NMAX  = 23,
  parameter int STEP  = 8,
  parameter int AGE_W = 8,
  parameter int ZMAX  = 15,
  parameter int ZW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NMAX-1:0][AGE_W-1:0] age,
  input  logic [ZW-1:0]              zrun,
  input  logic                       warm,
  output pdm_pkg::pdm_verdict_t      verdict
);

  logic [NMAX-1:0] win_zero;  // window n+1 fails if the current bit is 0
  logic [NMAX-1:0] win_one;   // window n+1 fails if the current bit is 1
  logic            zero_hit;

  // A zero leaves the window with only the stored ones, so rule n needs the
  // n-th stored one inside it. A one supplies one itself, so the (n-1)-th is enough.
  for (genvar n = 1; n <= NMAX; n++) begin : g_rule
    localparam int THR = pdm_pkg::win_len(STEP, n);

    assign win_zero[n-1] = (int'(age[n-1]) >= THR);

    if (n == 1) begin : g_first
      assign win_one[n-1] = 1'b0;
    end else begin : g_rest
      assign win_one[n-1] = (int'(age[n-2]) >= THR);
    end
  end

  assign zero_hit        = (int'(zrun) >= ZMAX);
  assign verdict.if_zero = zero_hit | (warm & (|win_zero));
  assign verdict.if_one  = warm & (|win_one);

  // R3
  one_no_worse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_one & ~win_zero) == 0);

endmodule

// File: rtl/pdm_density_guard.sv
module pdm_density_guard #(
  parameter int STEP = 8,
  parameter int NMAX = 23,
  parameter int ZMAX = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  input  logic enforce_en,
  output logic bit_out,
  output logic out_vld,
  output logic viol
);

  localparam int WMAX  = pdm_pkg::win_len(STEP, NMAX);
  localparam int AGE_W = $clog2(WMAX + 1);
  localparam int ZW    = $clog2(ZMAX + 1);
  localparam int SW    = $clog2(WMAX + 1);

  logic [NMAX-1:0][AGE_W-1:0] age;
  logic [ZW-1:0]              zrun;
  logic                       warm;
  pdm_pkg::pdm_verdict_t      verdict;
  logic                       pick_bit;
  logic                       pick_viol;

  // Outgoing bit: a zero survives unless enforcement needs a one here.
  always_comb begin
    pick_bit  = bit_in | (enforce_en & verdict.if_zero);
    pick_viol = pick_bit ? verdict.if_one : verdict.if_zero;
  end

  pdm_age_hist #(
    .NMAX   (NMAX),
    .AGE_W  (AGE_W),
    .AGE_CAP(WMAX)
  ) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (bit_vld),
    .one_in(pick_bit),
    .age   (age)
  );

  pdm_run_track #(
    .ZMAX(ZMAX),
    .ZW  (ZW),
    .WMAX(WMAX),
    .SW  (SW)
  ) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (bit_vld),
    .one_in(pick_bit),
    .zrun  (zrun),
    .warm  (warm)
  );

  pdm_rule_eval #(
    .NMAX (NMAX),
    .STEP (STEP),
    .AGE_W(AGE_W),
    .ZMAX (ZMAX),
    .ZW   (ZW)
  ) u_eval (
    .clk    (clk),
    .rst_n  (rst_n),
    .age    (age),
    .zrun   (zrun),
    .warm   (warm),
    .verdict(verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out <= 1'b0;
      out_vld <= 1'b0;
      viol    <= 1'b0;
    end else begin
      out_vld <= bit_vld;
      viol    <= bit_vld & pick_viol;
      if (bit_vld) bit_out <= pick_bit;
    end
  end

  // R7
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> out_vld);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !out_vld && !viol && $stable(bit_out));

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !$past(enforce_en) |-> bit_out == $past(bit_in));

  // R5
  ones_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && $past(bit_in) |-> bit_out);

  // R5
  enforce_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && $past(enforce_en) && !bit_out |-> !viol);

endmodule

// File: tb/pdm_density_guard_tb.sv
module pdm_density_guard_tb;

  localparam int STEP = 8;
  localparam int NMAX = 23;
  localparam int ZMAX = 15;
  localparam int WMAX = STEP * (NMAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic enforce_en = 1'b0;
  logic bit_out, out_vld, viol;

  always #4 clk = ~clk;

  pdm_density_guard #(.STEP(STEP), .NMAX(NMAX), .ZMAX(ZMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .enforce_en(enforce_en), .bit_out(bit_out), .out_vld(out_vld), .viol(viol)
  );

  typedef struct {
    logic  b;
    logic  v;
    string tag;
  } exp_t;

  exp_t  sbq[$];
  exp_t  mon_item;
  bit    mhist[$];       // outgoing bits, newest at the back
  int    mseen    = 0;
  int    checks   = 0;
  int    errors   = 0;
  bit    finished = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference: count ones directly in the stored outgoing bits.
  function automatic bit ref_break(input bit c);
    int z = 0;
    for (int j = mhist.size() - 1; j >= 0; j--) begin
      if (mhist[j] || z >= ZMAX) break;
      z++;
    end
    if (!c && z >= ZMAX) return 1'b1;
    if (mseen >= WMAX) begin
      for (int n = 1; n <= NMAX; n++) begin
        int w = STEP * (n + 1);
        int cnt = int'(c);
        for (int j = 0; j < w - 1 && j < mhist.size(); j++)
          cnt += int'(mhist[mhist.size() - 1 - j]);
        if (cnt < n) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic drive_bit(input bit b, input bit en, input string tag);
    bit   o;
    exp_t e;
    o = b;
    if (!b && en && ref_break(1'b0)) o = 1'b1;
    e.b = o;
    e.v = ref_break(o);
    e.tag = tag;
    @(negedge clk);
    sbq.push_back(e);
    bit_in = b;
    bit_vld = 1'b1;
    enforce_en = en;
    mhist.push_back(o);
    if (mhist.size() > WMAX - 1) void'(mhist.pop_front());
    if (mseen < WMAX) mseen++;
  endtask

  task automatic idle(input int n, input bit noise);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b0;
      bit_in = noise;
    end
  endtask

  task automatic drain();
    idle(3, 1'b0);
    chk(sbq.size() == 0, "R7", "pending results", sbq.size(), 0);
  endtask

  task automatic step_lfsr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: pops one expected item for every output strobe.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_vld) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R7", "unexpected out_vld", 1, 0);
        end else begin
          mon_item = sbq.pop_front();
          chk(bit_out == mon_item.b, mon_item.tag, "bit_out", int'(bit_out), int'(mon_item.b));
          chk(viol == mon_item.v, mon_item.tag, "viol", int'(viol), int'(mon_item.v));
        end
      end else if (viol) begin
        chk(1'b0, "R7", "viol without out_vld", 1, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    chk(out_vld == 0 && viol == 0 && bit_out == 0, "R1", "reset outputs",
        int'({bit_out, out_vld, viol}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 0 && viol == 0, "R1", "outputs after reset", int'({out_vld, viol}), 0);

    // R2: zero-run rule active from the first bit
    for (int i = 0; i < 20; i++) drive_bit(1'b0, 1'b0, "R2");
    drive_bit(1'b1, 1'b0, "R2");

    // R3: one-in-fifteen across the 192-bit mark
    for (int i = 0; mseen < WMAX; i++) drive_bit(i % 15 == 0, 1'b0, "R3");
    for (int i = 0; i < 150; i++) drive_bit(i % 15 == 0, 1'b0, "R3");

    // R4: dense and near-limit patterns in monitor mode
    for (int i = 0; i < 60; i++) drive_bit(1'b1, 1'b0, "R4");
    for (int i = 0; i < 200; i++) drive_bit(i % 8 == 0, 1'b0, "R4");
    for (int i = 0; i < 250; i++) drive_bit(i % 9 == 0, 1'b0, "R3");

    // R8: idle cycles with a one on the input count for nothing
    idle(6, 1'b1);
    for (int i = 0; i < 30; i++) drive_bit(1'b0, 1'b0, "R8");
    drive_bit(1'b1, 1'b0, "R8");

    // R5: enforcement on an all-zero stream
    for (int i = 0; i < 300; i++) drive_bit(1'b0, 1'b1, "R5");

    // R6: sparse stream, forced ones feed later windows
    for (int i = 0; i < 300; i++) begin
      step_lfsr();
      drive_bit(lf[3:0] == 4'd0, 1'b1, "R6");
    end

    // R5: enforcement switched bit by bit
    for (int i = 0; i < 300; i++) begin
      step_lfsr();
      drive_bit(lf[3:0] == 4'd0, lf[7], "R5");
    end
    drain();

    // R7: single bit gives a single-cycle strobe
    drive_bit(1'b1, 1'b0, "R7");
    @(negedge clk);
    bit_vld = 1'b0;
    chk(out_vld == 1, "R7", "strobe one cycle after bit", int'(out_vld), 1);
    @(negedge clk);
    chk(out_vld == 0, "R7", "strobe drops", int'(out_vld), 0);

    // R1: reset in the middle of a run clears the history
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_vld == 0 && viol == 0 && bit_out == 0, "R1", "mid-run reset outputs",
        int'({bit_out, out_vld, viol}), 0);
    mhist.delete();
    mseen = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 18; i++) drive_bit(1'b0, 1'b0, "R1");
    for (int i = 0; i < 60; i++) drive_bit(i % 20 == 0, 1'b1, "R1");
    drain();

    finish_run();
  end

endmodule